// File: doc/BRIEF.md
# Two-Phase Decade Rate-Multiplier Tone Synthesizer

This block makes a programmable low-frequency square wave from a fast reference clock. The reference is a 20 MHz clock with two opposite phases, and the model steps through it on a 40 MHz system clock. Even ticks stand for one phase and odd ticks for the other. A three-and-a-half-decade BCD rate multiplier counts the even ticks in windows of 4000. In each window it passes exactly N of them as pulses, where N is the programmed word. Every odd tick gives one unconditional pulse.

The two pulse streams never land on the same tick, so merging them adds the rates: 20 MHz plus N times 5 kHz. A divide chain of 2, 10 and 50 then reduces the merged train by 1000. The result is a square wave from 20 kHz to 39.995 kHz in 5 Hz steps.

The frequency word is loaded into a holding register with a strobe. It takes effect only at the next window boundary, so a change never breaks a window that is already running. The block also raises a one-tick window-end signal, which lets further sections be cascaded.

Top module: `rate_synth`

## Requirements
- R1: A synchronous reset clears the phase, the decade counters, the divide chain, the holding word and the active word. While reset is held and on the first tick after it, `tone_out` and `win_end` are low, and the first tick after reset is an even tick.
- R2: Ticks alternate strictly between even and odd. Every odd tick contributes one merged pulse, whatever word is programmed.
- R3: The rate multiplier emits pulses only on even ticks. Over each window of 4000 even ticks it emits exactly N = 1000·T + 100·H + 10·E + U pulses, where T, H, E and U are the active digits.
- R4: Pulse placement follows decade weighting. Number the even ticks of a window j = 0..3999 and define the state of a stage as its digit of j: stage A is j mod 4, stage B is (j/4) mod 10, stage C is (j/40) mod 10, stage D is (j/400) mod 10. The tick belongs to the first stage, in the order A, B, C, D, whose state is not its last value (3 for A, 9 for the others). If no stage qualifies, the tick gives no pulse. The owning stage, with state s, digit d and k = 3 for A or 9 otherwise, pulses when ((s·d) mod k) + d ≥ k. The digits are T for A, H for B, E for C and U for D.
- R5: On a clock edge with `freq_load` high, `freq_bcd` is captured into the holding word. The fields are thousands [15:12], hundreds [11:8], tens [7:4] and units [3:0]. A thousands digit above 3 is stored as 3, and any other digit above 9 is stored as 9.
- R6: The active word copies the holding word only at the edge that ends even tick j = 3999. Loads made inside a window have no effect on pulses until the next window starts.
- R7: `win_end` is high exactly during even tick j = 3999 of each window, for one tick, and is low on every other tick.
- R8: Let M be the count of merged pulses since reset, modulo 1000. `tone_out` is high when M ≥ 500 and low otherwise, and it updates on the tick after the pulse that changes M.
- R9: Across two whole windows, the number of rising edges on `tone_out` is within one of 2·(4000+N)/1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; even and odd ticks are the two reference phases |
| rst | input | 1 | Synchronous reset, active high |
| freq_bcd | input | 16 | BCD frequency word: thousands, hundreds, tens, units |
| freq_load | input | 1 | Load strobe for the holding word |
| win_end | output | 1 | High on the last even tick of each 4000-tick window |
| tone_out | output | 1 | Divided square-wave output |

## Verification
Some properties are checked on every cycle. Multiplier pulses never fall on odd ticks. The phase toggles on every tick. The active word holds still except at a window end, and its digits always stay legal. The window-end flag never lasts two ticks, and the output moves only after a merged pulse. Whether the pulse count per window equals N, where those pulses fall, and how clamping and window-aligned loading affect the output frequency can only be shown by the bench. Its scenarios are a tick-accurate model run with N = 0, 1, 1999 and 3999, an out-of-range word, loads in mid-window and a reset during operation.

// File: rtl/rate_synth.sv
module rate_synth #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 10,
  parameter int DIV_C = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] freq_bcd,
  input  logic        freq_load,
  output logic        win_end,
  output logic        tone_out
);
  localparam int WA = (DIV_A > 2) ? $clog2(DIV_A) : 1;
  localparam int WB = (DIV_B > 2) ? $clog2(DIV_B) : 1;
  localparam int WC = (DIV_C > 2) ? $clog2(DIV_C) : 1;
  localparam logic [WA-1:0] LAST_A = WA'(DIV_A - 1);
  localparam logic [WB-1:0] LAST_B = WB'(DIV_B - 1);
  localparam logic [WC-1:0] LAST_C = WC'(DIV_C - 1);
  localparam logic [WC-1:0] HALF_C = WC'(DIV_C / 2);

  logic          ph;
  logic [1:0]    s0;
  logic [3:0]    s1, s2, s3;
  logic [15:0]   hold_q, act_q;
  logic [WA-1:0] da;
  logic [WB-1:0] db;
  logic [WC-1:0] dc;
  logic          t0, t1, t2, t3, last_slot, rm_gate, rm_pulse, merged;

  function automatic logic slot_gate(input int s, input int d, input int k);
    return (((s * d) % k) + d) >= k;
  endfunction

  function automatic logic [15:0] clamp_word(input logic [15:0] w);
    logic [3:0] d3, d2, d1, d0;
    d3 = (w[15:12] > 4'd3) ? 4'd3 : w[15:12];
    d2 = (w[11:8]  > 4'd9) ? 4'd9 : w[11:8];
    d1 = (w[7:4]   > 4'd9) ? 4'd9 : w[7:4];
    d0 = (w[3:0]   > 4'd9) ? 4'd9 : w[3:0];
    return {d3, d2, d1, d0};
  endfunction

  assign t0 = (s0 == 2'd3);
  assign t1 = (s1 == 4'd9);
  assign t2 = (s2 == 4'd9);
  assign t3 = (s3 == 4'd9);
  assign last_slot = t0 & t1 & t2 & t3;

  always_comb begin
    if (!t0)      rm_gate = slot_gate(int'(s0), int'(act_q[15:12]), 3);
    else if (!t1) rm_gate = slot_gate(int'(s1), int'(act_q[11:8]), 9);
    else if (!t2) rm_gate = slot_gate(int'(s2), int'(act_q[7:4]), 9);
    else if (!t3) rm_gate = slot_gate(int'(s3), int'(act_q[3:0]), 9);
    else          rm_gate = 1'b0;
  end

  assign rm_pulse = ~ph & rm_gate;
  assign merged   = ph | rm_pulse;
  assign win_end  = ~ph & last_slot;
  assign tone_out = (dc >= HALF_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= 1'b0;
      s0     <= '0;
      s1     <= '0;
      s2     <= '0;
      s3     <= '0;
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      ph <= ~ph;
      if (freq_load) hold_q <= clamp_word(freq_bcd);
      if (!ph) begin
        s0 <= t0 ? 2'd0 : s0 + 2'd1;
        if (t0)                s1 <= t1 ? 4'd0 : s1 + 4'd1;
        if (t0 && t1)          s2 <= t2 ? 4'd0 : s2 + 4'd1;
        if (t0 && t1 && t2)    s3 <= t3 ? 4'd0 : s3 + 4'd1;
        if (last_slot)         act_q <= hold_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      da <= '0;
      db <= '0;
      dc <= '0;
    end else if (merged) begin
      da <= (da == LAST_A) ? '0 : da + 1'b1;
      if (da == LAST_A) begin
        db <= (db == LAST_B) ? '0 : db + 1'b1;
        if (db == LAST_B) dc <= (dc == LAST_C) ? '0 : dc + 1'b1;
      end
    end
  end
endmodule

module rate_synth_chk (
  input logic        clk,
  input logic        rst,
  input logic        ph,
  input logic        rm_pulse,
  input logic        merged,
  input logic        win_end,
  input logic        tone_out,
  input logic [15:0] act_q
);
  AST_RM_EVEN_ONLY: assert property (@(posedge clk) disable iff (rst) rm_pulse |-> !ph); // R3
  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (rst) ph |=> !ph); // R2
  AST_PHASE_RET: assert property (@(posedge clk) disable iff (rst) !ph |=> ph); // R2
  AST_ACT_WINDOW: assert property (@(posedge clk) disable iff (rst) !win_end |=> $stable(act_q)); // R6
  AST_DIGITS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (act_q[15:12] <= 4'd3) && (act_q[11:8] <= 4'd9) && (act_q[7:4] <= 4'd9) && (act_q[3:0] <= 4'd9)); // R5
  AST_WIN_SINGLE: assert property (@(posedge clk) disable iff (rst) win_end |=> !win_end); // R7
  AST_OUT_ON_PULSE: assert property (@(posedge clk) disable iff (rst) !$stable(tone_out) |-> $past(merged)); // R8
endmodule

bind rate_synth rate_synth_chk i_chk (
  .clk(clk), .rst(rst), .ph(ph), .rm_pulse(rm_pulse), .merged(merged),
  .win_end(win_end), .tone_out(tone_out), .act_q(act_q)
);

// File: tb/test_rate_synth.sv
module test_rate_synth;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] freq_bcd = 16'h0000;
  logic        freq_load = 1'b0;
  logic        win_end, tone_out;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit done = 0;

  int m_ph = 0, m_slot = 0, m_act = 0, m_hold = 0, m_mc = 0;

  always #5 clk = ~clk;

  rate_synth i_rate_synth (
    .clk(clk), .rst(rst), .freq_bcd(freq_bcd), .freq_load(freq_load),
    .win_end(win_end), .tone_out(tone_out)
  );

  function automatic bit wt(int s, int d, int k);
    return (((s * d) % k) + d) >= k;
  endfunction

  // R4 placement rule, written from the slot index
  function automatic bit slot_pulse(int j, int n);
    int a, b, c, e;
    a = j % 4;
    if (a < 3) return wt(a, n / 1000, 3);
    b = (j / 4) % 10;
    if (b < 9) return wt(b, (n / 100) % 10, 9);
    c = (j / 40) % 10;
    if (c < 9) return wt(c, (n / 10) % 10, 9);
    e = (j / 400) % 10;
    if (e < 9) return wt(e, n % 10, 9);
    return 0;
  endfunction

  // R5 clamping
  function automatic int decode(logic [15:0] w);
    int d3, d2, d1, d0;
    d3 = (w[15:12] > 3) ? 3 : int'(w[15:12]);
    d2 = (w[11:8] > 9) ? 9 : int'(w[11:8]);
    d1 = (w[7:4] > 9) ? 9 : int'(w[7:4]);
    d0 = (w[3:0] > 9) ? 9 : int'(w[3:0]);
    return d3 * 1000 + d2 * 100 + d1 * 10 + d0;
  endfunction

  function automatic logic [15:0] to_bcd(int n);
    return {4'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  always @(posedge clk) begin
    bit p;
    started <= 1;
    if (rst) begin
      m_ph = 0; m_slot = 0; m_act = 0; m_hold = 0; m_mc = 0;
    end else begin
      if (m_ph == 0) begin
        p = slot_pulse(m_slot, m_act);       // R3 R4
        if (m_slot == 3999) begin
          m_act = m_hold;                    // R6
          m_slot = 0;
        end else m_slot++;
      end else p = 1;                        // R2
      if (freq_load) m_hold = decode(freq_bcd);
      if (p) m_mc = (m_mc + 1) % 1000;
      m_ph ^= 1;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      bit exp_out, exp_we;
      exp_out = (m_mc >= 500);
      exp_we  = (m_ph == 0) && (m_slot == 3999);
      checks++;
      if (tone_out !== exp_out) begin
        failures++;
        $display("FAIL R8 (R2 R3 R4 R6) tone_out got %0d exp %0d at %0t", tone_out, exp_out, $time);
      end
      checks++;
      if (win_end !== exp_we) begin
        failures++;
        $display("FAIL R7 win_end got %0d exp %0d at %0t", win_end, exp_we, $time);
      end
    end
  end

  task automatic check_eq(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic load_word(logic [15:0] w);
    @(negedge clk);
    freq_bcd = w;
    freq_load = 1'b1;
    @(negedge clk);
    freq_load = 1'b0;
  endtask

  // R9 frequency over two whole windows
  task automatic run_freq(logic [15:0] w, int n);
    int edges, ex, lo, hi;
    bit prev;
    load_word(w);
    while (win_end !== 1'b1) @(negedge clk);
    @(negedge clk);
    edges = 0;
    prev = tone_out;
    repeat (16000) begin
      @(negedge clk);
      if (!prev && tone_out) edges++;
      prev = tone_out;
    end
    ex = (2 * (4000 + n)) / 1000;
    lo = ex - 1;
    hi = ex + 1;
    checks++;
    if (edges < lo || edges > hi) begin
      failures++;
      $display("FAIL R9 N=%0d edges got %0d exp %0d..%0d", n, edges, lo, hi);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1 tone_out in reset", int'(tone_out), 0);
    check_eq("R1 win_end in reset", int'(win_end), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 tone_out after reset", int'(tone_out), 0);
    run_freq(to_bcd(0), 0);       // R2 fixed phase alone
    run_freq(to_bcd(1), 1);       // R3 single pulse per window
    run_freq(to_bcd(1999), 1999); // R4 mixed digits
    run_freq(to_bcd(3999), 3999); // R3 full scale
    run_freq(16'hFAFB, 3999);     // R5 clamped to 3-9-9-9
    // R6 loads inside a window take effect only at its end
    load_word(to_bcd(250));
    repeat (1500) @(negedge clk);
    load_word(to_bcd(3000));
    repeat (3000) @(negedge clk);
    // R1 reset during operation
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_eq("R1 tone_out mid reset", int'(tone_out), 0);
    check_eq("R1 win_end mid reset", int'(win_end), 0);
    rst = 1'b0;
    repeat (9000) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule